// File: doc/BRIEF.md
# Raster Framebuffer Setup Register Bank

This block is the memory-mapped settings store for a raster video framebuffer. A host reaches it over a small word-oriented slave bus with a one-cycle write strobe and a read strobe answered one cycle later. It stores the line and frame geometry (visible size, sync edges, scan totals), the framebuffer start address, a DMA burst length and a pixel-clock source choice, and drives every stored value straight out to the timing generator and the pixel fetch engine that sit beside it.

A soft-hold bit in the control word keeps the downstream engine stopped until software clears it. Changing the visible size or the control word while the engine runs, or loading a new framebuffer start address, raises a one-cycle refresh pulse so the fetch side can restart its frame. The start-address register accepts only 32-byte aligned values and masks them with a build-time mask; a second, read-only slot shows the address in use. Accesses to slots that do not exist, and writes to the read-only slot, raise a one-cycle error strobe.

Top module: `fbctl_regs`

## Requirements
- R1: The slot is the byte address shifted right by two (the two low address bits are ignored). Slots: 0 control, 1 visible width, 2 line sync start, 3 line sync end, 4 line total, 5 visible height, 6 frame sync start, 7 frame sync end, 8 frame total, 9 start address, 10 start address in use (read-only), 11 burst length, 12 clock source. Each slot reads back the last value stored in it.
- R2: After reset the control word is 1, visible width is 640, visible height is 480 and every other slot is 0.
- R3: `engine_en` is high exactly while bit 0 of the control word is 0.
- R4: A write to slot 9 whose bits 4:0 are not all zero is discarded: the slot keeps its old value and no refresh pulse is raised.
- R5: An aligned write to slot 9 stores the written value ANDed with the parameter `BASE_MASK` (all ones by default) and raises `refresh_pulse`.
- R6: Slot 10 reads the current value of slot 9; a write to slot 10 changes nothing and raises `bus_err`.
- R7: A write to slot 0, 1 or 5 stores the value and raises `refresh_pulse` only if bit 0 of the control word is 0 once the write has taken effect.
- R8: Writes to slots 2, 3, 4, 6, 7, 8, 11 and 12 store the value and raise no refresh pulse.
- R9: A read or write to slot 13 or above returns 0 on reads, changes no slot, and raises `bus_err`.
- R10: Read data and `bus_rvalid` appear in the cycle after the cycle where `bus_rd` is sampled high; `bus_rvalid` is low otherwise.
- R11: `line_bytes` equals twice the visible width (two bytes per pixel).
- R12: `refresh_pulse` and `bus_err` are high for exactly the one cycle after the qualifying access is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | One-cycle full-word write strobe |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| bus_err | output | 1 | One-cycle error strobe for bad slot or read-only write |
| engine_en | output | 1 | Downstream engine run enable |
| refresh_pulse | output | 1 | One-cycle resize / invalidate event |
| cfg_hres | output | 32 | Visible width in pixels |
| cfg_hsync_start | output | 32 | Line sync start |
| cfg_hsync_end | output | 32 | Line sync end |
| cfg_htotal | output | 32 | Line total |
| cfg_vres | output | 32 | Visible height in lines |
| cfg_vsync_start | output | 32 | Frame sync start |
| cfg_vsync_end | output | 32 | Frame sync end |
| cfg_vtotal | output | 32 | Frame total |
| cfg_base | output | 32 | Framebuffer start address |
| cfg_burst | output | 32 | DMA burst length |
| cfg_clk_sel | output | 32 | Pixel-clock source choice |
| line_bytes | output | 32 | Bytes per framebuffer line |

## Verification
The geometry writes are tried once with the engine held and once with it running, which separates a refresh pulse keyed on the control bit after the write from one keyed on any write to those slots. The start address is written with a misaligned value and then an aligned one carrying bits above a narrowed mask, which tells rejection apart from masking. Reads sweep every defined slot with distinct values plus several slots past the end, so a wrong slot order, a stale mirror in slot 10 or a leaking out-of-range read shows up as a data mismatch in the scoreboard.

// File: rtl/fbreg_pkg.sv
package fbreg_pkg;

    localparam int REG_W      = 32;
    localparam int NUM_REGS   = 13;
    localparam int SLOT_W     = 4;
    localparam int ALIGN_BITS = 5;
    localparam int HOLD_BIT   = 0;

    localparam logic [REG_W-1:0] WIDTH_DEFAULT  = 32'd640;
    localparam logic [REG_W-1:0] HEIGHT_DEFAULT = 32'd480;

    typedef enum logic [SLOT_W-1:0] {
        SL_CTRL      = 4'd0,
        SL_WIDTH     = 4'd1,
        SL_HSYNC_ON  = 4'd2,
        SL_HSYNC_OFF = 4'd3,
        SL_HTOTAL    = 4'd4,
        SL_HEIGHT    = 4'd5,
        SL_VSYNC_ON  = 4'd6,
        SL_VSYNC_OFF = 4'd7,
        SL_VTOTAL    = 4'd8,
        SL_BASE      = 4'd9,
        SL_BASE_USED = 4'd10,
        SL_BURST     = 4'd11,
        SL_CLK_SRC   = 4'd12
    } slot_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic              known;
        slot_e             slot;
        logic [REG_W-1:0]  data;
    } bus_req_t;

    function automatic logic is_aligned(input logic [REG_W-1:0] v);
        return v[ALIGN_BITS-1:0] == '0;
    endfunction

    function automatic logic [REG_W-1:0] slot_default(input int idx);
        case (idx)
            int'(SL_CTRL):   return REG_W'(1) << HOLD_BIT;
            int'(SL_WIDTH):  return WIDTH_DEFAULT;
            int'(SL_HEIGHT): return HEIGHT_DEFAULT;
            default:         return '0;
        endcase
    endfunction

    function automatic logic is_geometry(input slot_e s);
        return (s == SL_CTRL) || (s == SL_WIDTH) || (s == SL_HEIGHT);
    endfunction

endpackage

// File: rtl/fbreg_decode.sv
module fbreg_decode
    import fbreg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [REG_W-1:0]  wdata,
    output bus_req_t          req
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    logic              unused_lsb;

    assign word       = addr[ADDR_W-1:2];
    assign unused_lsb = ^addr[1:0];

    always_comb begin
        req.wr    = wr;
        req.rd    = rd;
        req.data  = wdata;
        req.known = (32'(word) < NUM_REGS);
        req.slot  = req.known ? slot_e'(word[SLOT_W-1:0]) : SL_CTRL;
    end
endmodule

// File: rtl/fbreg_bank.sv
module fbreg_bank
    import fbreg_pkg::*;
#(
    parameter logic [31:0] BASE_MASK = 32'hFFFF_FFFF
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_req_t         req,
    output logic [REG_W-1:0] regs [NUM_REGS],
    output logic             base_taken,
    output logic             geom_write
);
    logic hit;
    assign hit = req.wr && req.known;

    assign base_taken = hit && (req.slot == SL_BASE) && is_aligned(req.data);
    assign geom_write = hit && is_geometry(req.slot);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
        if (i == int'(SL_BASE_USED)) begin : g_view
            assign regs[i] = '0;
        end else if (i == int'(SL_BASE)) begin : g_base
            always_ff @(posedge clk) begin
                if (rst)             regs[i] <= slot_default(i);
                else if (base_taken) regs[i] <= req.data & BASE_MASK;
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (rst)                               regs[i] <= slot_default(i);
                else if (hit && req.slot == slot_e'(i)) regs[i] <= req.data;
            end
        end
    end

    AST_MISALIGNED_KEEP: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.known && req.slot == SL_BASE && !is_aligned(req.data))
        |=> $stable(regs[SL_BASE])) else $error("misaligned base stored"); // R4

    AST_RO_UNCHANGED: assert property (@(posedge clk) disable iff (rst)
        (req.wr && (!req.known || req.slot == SL_BASE_USED))
        |=> $stable(regs[SL_BASE]) && $stable(regs[SL_CTRL])) else $error("ignored write changed state"); // R9
endmodule

// File: rtl/fbreg_resp.sv
module fbreg_resp
    import fbreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  bus_req_t         req,
    input  logic [REG_W-1:0] regs [NUM_REGS],
    input  logic             base_taken,
    input  logic             geom_write,
    output logic [REG_W-1:0] rdata,
    output logic             rvalid,
    output logic             err,
    output logic             refresh
);
    logic             run_after;
    logic             bad_access;
    logic [REG_W-1:0] rd_mux;

    always_comb begin
        if (req.slot == SL_CTRL) run_after = !req.data[HOLD_BIT];
        else                     run_after = !regs[SL_CTRL][HOLD_BIT];
    end

    assign bad_access = ((req.wr || req.rd) && !req.known)
                      || (req.wr && req.known && req.slot == SL_BASE_USED);

    always_comb begin
        if (!req.known)                  rd_mux = '0;
        else if (req.slot == SL_BASE_USED) rd_mux = regs[SL_BASE];
        else                             rd_mux = regs[req.slot];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata   <= '0;
            rvalid  <= 1'b0;
            err     <= 1'b0;
            refresh <= 1'b0;
        end else begin
            rvalid  <= req.rd;
            if (req.rd) rdata <= rd_mux;
            err     <= bad_access;
            refresh <= base_taken || (geom_write && run_after);
        end
    end

    AST_READ_VALID: assert property (@(posedge clk) disable iff (rst)
        req.rd |=> rvalid) else $error("read not answered"); // R10

    AST_RO_ERR: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.known && req.slot == SL_BASE_USED) |=> err) else $error("read-only write not flagged"); // R6

    AST_UNKNOWN_ERR: assert property (@(posedge clk) disable iff (rst)
        ((req.wr || req.rd) && !req.known) |=> err) else $error("bad slot not flagged"); // R9

    AST_REFRESH_CAUSE: assert property (@(posedge clk) disable iff (rst)
        refresh |-> $past(req.wr)) else $error("refresh without write"); // R12

    AST_QUIET_WRITE: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.known && !is_geometry(req.slot) && req.slot != SL_BASE)
        |=> !refresh) else $error("refresh on plain slot"); // R8
endmodule

// File: rtl/fbctl_regs.sv
module fbctl_regs
    import fbreg_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter logic [31:0] BASE_MASK = 32'hFFFF_FFFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    output logic              bus_err,
    output logic              engine_en,
    output logic              refresh_pulse,
    output logic [31:0]       cfg_hres,
    output logic [31:0]       cfg_hsync_start,
    output logic [31:0]       cfg_hsync_end,
    output logic [31:0]       cfg_htotal,
    output logic [31:0]       cfg_vres,
    output logic [31:0]       cfg_vsync_start,
    output logic [31:0]       cfg_vsync_end,
    output logic [31:0]       cfg_vtotal,
    output logic [31:0]       cfg_base,
    output logic [31:0]       cfg_burst,
    output logic [31:0]       cfg_clk_sel,
    output logic [31:0]       line_bytes
);
    bus_req_t         req;
    logic [REG_W-1:0] regs [NUM_REGS];
    logic             base_taken;
    logic             geom_write;

    fbreg_decode #(.ADDR_W(ADDR_W)) i_decode (
        .addr  (bus_addr),
        .wr    (bus_wr),
        .rd    (bus_rd),
        .wdata (bus_wdata),
        .req   (req)
    );

    fbreg_bank #(.BASE_MASK(BASE_MASK)) i_bank (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .regs       (regs),
        .base_taken (base_taken),
        .geom_write (geom_write)
    );

    fbreg_resp i_resp (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .regs       (regs),
        .base_taken (base_taken),
        .geom_write (geom_write),
        .rdata      (bus_rdata),
        .rvalid     (bus_rvalid),
        .err        (bus_err),
        .refresh    (refresh_pulse)
    );

    assign engine_en       = !regs[SL_CTRL][HOLD_BIT];
    assign cfg_hres        = regs[SL_WIDTH];
    assign cfg_hsync_start = regs[SL_HSYNC_ON];
    assign cfg_hsync_end   = regs[SL_HSYNC_OFF];
    assign cfg_htotal      = regs[SL_HTOTAL];
    assign cfg_vres        = regs[SL_HEIGHT];
    assign cfg_vsync_start = regs[SL_VSYNC_ON];
    assign cfg_vsync_end   = regs[SL_VSYNC_OFF];
    assign cfg_vtotal      = regs[SL_VTOTAL];
    assign cfg_base        = regs[SL_BASE];
    assign cfg_burst       = regs[SL_BURST];
    assign cfg_clk_sel     = regs[SL_CLK_SRC];
    assign line_bytes      = {regs[SL_WIDTH][REG_W-2:0], 1'b0};
endmodule

// File: tb/test_fbctl_regs.sv
module test_fbctl_regs;
    localparam int          PERIOD = 10;
    localparam int          AW     = 8;
    localparam logic [31:0] MASK   = 32'h00FF_FFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid, bus_err, engine_en, refresh_pulse;
    logic [31:0] cfg_hres, cfg_hsync_start, cfg_hsync_end, cfg_htotal;
    logic [31:0] cfg_vres, cfg_vsync_start, cfg_vsync_end, cfg_vtotal;
    logic [31:0] cfg_base, cfg_burst, cfg_clk_sel, line_bytes;

    int tests = 0, fails = 0;
    logic [31:0] model [13];
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #(PERIOD/2) clk = ~clk;

    fbctl_regs #(.ADDR_W(AW), .BASE_MASK(MASK)) i_fbctl_regs (
        .clk, .rst, .bus_addr, .bus_wr, .bus_rd, .bus_wdata, .bus_rdata,
        .bus_rvalid, .bus_err, .engine_en, .refresh_pulse,
        .cfg_hres, .cfg_hsync_start, .cfg_hsync_end, .cfg_htotal,
        .cfg_vres, .cfg_vsync_start, .cfg_vsync_end, .cfg_vtotal,
        .cfg_base, .cfg_burst, .cfg_clk_sel, .line_bytes
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data when the design returns it
    always @(negedge clk) begin
        if (!rst && bus_rvalid) begin
            if (exp_q.size() == 0) chk("R10 unexpected rvalid", 32'd1, 32'd0);
            else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
    end

    function automatic logic [31:0] model_read(input int slot);
        if (slot == 10) return model[9];
        if (slot > 12)  return '0;
        return model[slot];
    endfunction

    task automatic do_read(input int slot, input string tag);
        @(negedge clk);
        bus_addr = AW'(slot * 4 + (slot % 4));
        bus_rd   = 1'b1;
        exp_q.push_back(model_read(slot));
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
        chk({tag, " rvalid"}, 32'(bus_rvalid), 32'd1);
        chk({tag, " err"}, 32'(bus_err), 32'(slot > 12));
    endtask

    task automatic do_write(input int slot, input logic [31:0] v, input string tag);
        logic exp_ref, exp_err;
        exp_ref = 1'b0;
        exp_err = (slot > 12) || (slot == 10);
        if (slot == 9) begin
            if (v[4:0] == 5'd0) begin
                model[9] = v & MASK;
                exp_ref  = 1'b1;
            end
        end else if (slot == 0 || slot == 1 || slot == 5) begin
            model[slot] = v;
            exp_ref     = !model[0][0];
        end else if (slot <= 12 && slot != 10) begin
            model[slot] = v;
        end
        @(negedge clk);
        bus_addr  = AW'(slot * 4);
        bus_wdata = v;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        chk({tag, " refresh"}, 32'(refresh_pulse), 32'(exp_ref));
        chk({tag, " err"}, 32'(bus_err), 32'(exp_err));
        @(negedge clk);
        chk({tag, " R12 single-cycle"}, 32'({refresh_pulse, bus_err}), 32'd0);
    endtask

    initial begin
        #(PERIOD * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 13; i++) model[i] = '0;
        model[0] = 32'd1; model[1] = 32'd640; model[5] = 32'd480;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R2 reset state, R3 held, R11 line size
        chk("R2 hres", cfg_hres, 32'd640);
        chk("R2 vres", cfg_vres, 32'd480);
        chk("R2 base", cfg_base, 32'd0);
        chk("R3 engine held", 32'(engine_en), 32'd0);
        chk("R11 reset line", line_bytes, 32'd1280);
        chk("R10 idle rvalid", 32'(bus_rvalid), 32'd0);
        for (int s = 0; s < 13; s++) do_read(s, "R2 reset read");

        // R7 geometry write while held: no refresh
        do_write(1, 32'd800, "R7 held width");
        chk("R11 line after width", line_bytes, 32'd1600);
        do_write(0, 32'd0, "R7 release ctrl");
        chk("R3 engine runs", 32'(engine_en), 32'd1);
        do_write(5, 32'd600, "R7 running height");
        chk("R7 height out", cfg_vres, 32'd600);

        // R8 plain slots
        do_write(2, 32'h0000_0348, "R8 hs on");
        do_write(3, 32'h0000_03C8, "R8 hs off");
        do_write(4, 32'h0000_0420, "R8 htot");
        do_write(6, 32'h0000_0259, "R8 vs on");
        do_write(7, 32'h0000_025D, "R8 vs off");
        do_write(8, 32'h0000_0274, "R8 vtot");
        do_write(11, 32'h0000_0010, "R8 burst");
        do_write(12, 32'h0000_0003, "R8 clksel");
        chk("R8 burst out", cfg_burst, 32'h10);
        chk("R8 clksel out", cfg_clk_sel, 32'h3);

        // R4 misaligned base rejected, R5 aligned masked
        do_write(9, 32'h1234_5671, "R4 misaligned base");
        chk("R4 base kept", cfg_base, 32'd0);
        do_write(9, 32'hAB34_5680, "R5 aligned base");
        chk("R5 base masked", cfg_base, 32'h0034_5680);
        do_write(9, 32'hFFFF_FFF0, "R4 misaligned base 2");
        chk("R4 base kept 2", cfg_base, 32'h0034_5680);

        // R6 read-only slot
        do_write(10, 32'hDEAD_BEE0, "R6 ro write");
        chk("R6 base after ro", cfg_base, 32'h0034_5680);

        // R9 out of range
        do_write(13, 32'hFFFF_FFFF, "R9 write 13");
        do_write(15, 32'h0000_0001, "R9 write 15");
        chk("R9 engine unaffected", 32'(engine_en), 32'd1);
        do_read(13, "R9 read 13");
        do_read(63, "R9 read 63");

        // R1 full readback sweep
        for (int s = 0; s < 13; s++) do_read(s, "R1 sweep");

        // R3/R7 hold again: no refresh, then width change while held
        do_write(0, 32'd1, "R7 hold ctrl");
        chk("R3 engine held again", 32'(engine_en), 32'd0);
        do_write(1, 32'd1024, "R7 held width 2");
        chk("R11 line 1024", line_bytes, 32'd2048);
        do_write(0, 32'h0000_0002, "R7 release with other bits");
        do_read(0, "R1 ctrl readback");

        repeat (3) @(negedge clk);
        chk("R10 queue drained", 32'(exp_q.size()), 32'd0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule